// File: doc/BRIEF.md
# Buffered Four-Channel Input Capture Unit

This block timestamps events on four input pins. A free-running 16-bit counter is latched into one of four 16-bit capture registers, A to D, whenever a selected edge appears on the pin that belongs to that register. Each pin passes through a two-flop synchronizer. An optional noise filter can then require the pin to hold a new level for three sampled clocks before that level is accepted. Each pin has a two-bit edge selector: none, rising, falling or both.

Two mode inputs change the role of registers C and D. With its mode bit set, register C stops watching pin C and becomes a history register behind A. On every A capture, C receives the value that A held before, and A takes the new count in the same clock. Register D does the same behind B. Software reads and writes the registers, the counter and a capture-flag word through a small word-wide register port. Byte-wide writes are ignored.

Top module: `cap4_unit`

## Requirements
- R1: After reset, registers A, B, C and D read 0xFFFF, the counter reads 0x0000 and the flag word reads 0x0000.
- R2: Word writes (`bus_word`=1) at address 0..3 load A..D, at address 4 load the counter, and at address 5 clear flags. Reads at those addresses return the same items, and the flag word appears in bits 3:0. A write with `bus_word`=0 changes nothing. A capture in the same cycle as a write to the same register takes precedence.
- R3: Registers A and B always capture from pins 0 and 1. With the counter running and no filter, a pin change applied just after clock edge N stores the counter value that stands after edge N+2.
- R4: With its mode bit at 0, register C captures independently from pin 2, and register D from pin 3.
- R5: With `buf_c`=1, a capture on pin 0 moves the old A into C and loads the counter into A in the same clock, and pin 2 has no effect on C. `buf_d`=1 does the same for pin 1, B and D.
- R6: For pin i, `edge_sel[2i+1:2i]` selects the edge: 00 none, 01 rising, 10 falling, 11 both.
- R7: With `filt_en[i]`=1, a new level must appear on 3 consecutive synchronized samples before it is accepted. A 2-cycle pulse is dropped and a 3-cycle pulse is kept. An accepted edge applied just after edge N stores the count that stands after edge N+6.
- R8: A capture sets the matching bit of the flag word (bit 0 for A through bit 3 for D). A word write at address 5 clears the bits written as 1. A capture that arrives while its bit is being cleared leaves the bit set.
- R9: While `cnt_en`=1, the counter adds one on each clock and wraps from 0xFFFF to 0x0000. While `cnt_en`=0, it holds its value.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Operation clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Counter enable |
| cap_pin | input | 4 | Capture pins 0..3 for A..D |
| edge_sel | input | 8 | Two-bit edge selector per pin |
| filt_en | input | 4 | Noise-filter enable per pin |
| buf_c | input | 1 | C acts as history of A |
| buf_d | input | 1 | D acts as history of B |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_word | input | 1 | 1 = full-word access, 0 = byte access |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` |

## Verification
The bench stops the counter and sweeps a vector table of pins, edge selectors, filter settings and pulse widths. A design that ignores the selector, or lets a 2-cycle pulse through the filter, stores a count where the table expects none. With the counter running, it measures capture latency with and without the filter, so that a missing or extra register stage shows up as a count off by one. It follows A and B through successive captures in history mode. A design that shifted after loading, or let pin 2 still capture, would leave the wrong value in C. It also covers byte writes that must be dropped, flag clearing and the counter wrap.

// File: rtl/cap4_unit.sv
module cap4_unit #(
  parameter int W     = 16,
  parameter int FLT_N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_en,
  input  logic [3:0]   cap_pin,
  input  logic [7:0]   edge_sel,
  input  logic [3:0]   filt_en,
  input  logic         buf_c,
  input  logic         buf_d,
  input  logic [2:0]   bus_addr,
  input  logic         bus_wr,
  input  logic         bus_word,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata
);

  localparam logic [2:0] ADDR_CNT  = 3'd4;
  localparam logic [2:0] ADDR_FLAG = 3'd5;

  logic [W-1:0] cnt;
  logic [W-1:0] gr [4];
  logic [3:0]   flags;
  logic [3:0]   ev;
  logic [3:0]   cap;
  logic [3:0]   shift;
  logic         wr_word;

  assign wr_word = bus_wr & bus_word;
  assign cap     = {ev[3] & ~buf_d, ev[2] & ~buf_c, ev[1:0]};
  assign shift   = {ev[1] & buf_d, ev[0] & buf_c, 2'b00};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                             cnt <= '0;
    else if (wr_word && bus_addr == ADDR_CNT) cnt <= bus_wdata;
    else if (cnt_en)                        cnt <= cnt + 1'b1;

  for (genvar i = 0; i < 4; i++) begin : g_pin
    logic [1:0]       sy;
    logic [FLT_N-1:0] hist;
    logic             flt, lvl, lvl_q;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        sy <= '0; hist <= '0; flt <= 1'b0; lvl_q <= 1'b0;
      end else begin
        sy    <= {sy[0], cap_pin[i]};
        hist  <= {hist[FLT_N-2:0], sy[1]};
        if (&hist)       flt <= 1'b1;
        else if (~|hist) flt <= 1'b0;
        lvl_q <= lvl;
      end

    assign lvl   = filt_en[i] ? flt : sy[1];
    assign ev[i] = (edge_sel[2*i]   &  lvl & ~lvl_q) |
                   (edge_sel[2*i+1] & ~lvl &  lvl_q);
  end

  for (genvar j = 0; j < 4; j++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)                                    gr[j] <= '1;
      else if (cap[j])                               gr[j] <= cnt;
      else if (shift[j])                             gr[j] <= gr[j^2];
      else if (wr_word && bus_addr == 3'(j))         gr[j] <= bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~((wr_word && bus_addr == ADDR_FLAG) ? bus_wdata[3:0] : 4'h0)) | cap;

  always_comb
    case (bus_addr)
      3'd0, 3'd1, 3'd2, 3'd3: bus_rdata = gr[bus_addr[1:0]];
      ADDR_CNT:               bus_rdata = cnt;
      ADDR_FLAG:              bus_rdata = {{(W-4){1'b0}}, flags};
      default:                bus_rdata = '0;
    endcase

  a_r2_byte_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_word && bus_addr == 3'd0 && !ev[0]) |=> $stable(gr[0]));

  a_r3_capture_value: assert property (@(posedge clk) disable iff (!rst_n)
    ev[0] |=> gr[0] == $past(cnt));

  a_r5_shift_old_a: assert property (@(posedge clk) disable iff (!rst_n)
    (ev[0] && buf_c) |=> gr[2] == $past(gr[0]));

  a_r5_pin_c_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_c && !ev[0] && !(wr_word && bus_addr == 3'd2)) |=> $stable(gr[2]));

  a_r8_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    cap[1] |=> flags[1]);

  a_r9_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && cnt == '1 && !(wr_word && bus_addr == ADDR_CNT)) |=> cnt == '0);

endmodule

// File: tb/cap4_unit_tb.sv
module cap4_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cnt_en = 1'b0;
  logic [3:0]  cap_pin = '0;
  logic [7:0]  edge_sel = '0;
  logic [3:0]  filt_en = '0;
  logic        buf_c = 1'b0, buf_d = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_word = 1'b1;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  cap4_unit u_dut (.clk, .rst_n, .cnt_en, .cap_pin, .edge_sel, .filt_en, .buf_c, .buf_d,
                   .bus_addr, .bus_wr, .bus_word, .bus_wdata, .bus_rdata);

  // {pin[1:0], esel[1:0], filt, width[2:0], expect_capture}
  localparam logic [8:0] VEC [8] = '{
    {2'd0, 2'b01, 1'b0, 3'd4, 1'b1},
    {2'd1, 2'b10, 1'b0, 3'd4, 1'b1},
    {2'd2, 2'b11, 1'b0, 3'd1, 1'b1},
    {2'd3, 2'b00, 1'b0, 3'd4, 1'b0},
    {2'd0, 2'b01, 1'b1, 3'd2, 1'b0},
    {2'd1, 2'b10, 1'b1, 3'd3, 1'b1},
    {2'd2, 2'b01, 1'b1, 3'd5, 1'b1},
    {2'd3, 2'b11, 1'b1, 3'd1, 1'b0}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d, input logic word = 1'b1);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_word = word; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_word = 1'b1;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic pulse(input int pin, input int width);
    @(negedge clk);
    cap_pin[pin] = 1'b1;
    repeat (width) @(negedge clk);
    cap_pin[pin] = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  function automatic void summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endfunction

  initial begin
    #2_000_000;
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int k = 0; k < 4; k++) begin rd(3'(k), v); check("R1 reg", v, 16'hFFFF); end
    rd(3'd4, v); check("R1 counter", v, 16'h0000);
    rd(3'd5, v); check("R1 flags", v, 16'h0000);

    // R2 byte write ignored, word write lands
    wr(3'd0, 16'h1234, 1'b0);
    rd(3'd0, v); check("R2 byte write ignored", v, 16'hFFFF);
    wr(3'd3, 16'hBEEF);
    rd(3'd3, v); check("R2 word write", v, 16'hBEEF);

    // R4 R6 R7 vector table, counter stopped
    for (int i = 0; i < 8; i++) begin
      int pin;
      pin = int'(VEC[i][8:7]);
      edge_sel = 8'(VEC[i][6:5]) << (2*pin);
      filt_en  = 4'(VEC[i][4]) << pin;
      repeat (6) @(negedge clk);
      wr(3'(pin), 16'h0000);
      wr(3'd4, 16'h0100 + 16'(i));
      pulse(pin, int'(VEC[i][3:1]));
      rd(3'(pin), v);
      check("R4/R6/R7 vector", v, VEC[i][0] ? 16'h0100 + 16'(i) : 16'h0000);
    end
    filt_en = '0;
    repeat (6) @(negedge clk);

    // R3 latency unfiltered, R7 latency filtered
    edge_sel = 8'b0101_0101;
    cnt_en = 1'b1;
    wr(3'd4, 16'h1000);
    cap_pin[0] = 1'b1;
    repeat (10) @(negedge clk);
    rd(3'd0, v); check("R3 capture latency", v, 16'h1002);
    filt_en = 4'b0010;
    repeat (6) @(negedge clk);
    wr(3'd4, 16'h2000);
    cap_pin[1] = 1'b1;
    repeat (12) @(negedge clk);
    rd(3'd1, v); check("R7 filtered latency", v, 16'h2006);
    cnt_en = 1'b0;
    cap_pin = '0; filt_en = '0;
    repeat (12) @(negedge clk);

    // R5 buffer mode
    buf_c = 1'b1; buf_d = 1'b1;
    edge_sel = 8'b1101_0101;
    wr(3'd0, 16'h00AA);
    wr(3'd4, 16'h0011);
    pulse(0, 3);
    rd(3'd0, v); check("R5 A new", v, 16'h0011);
    rd(3'd2, v); check("R5 C old A", v, 16'h00AA);
    wr(3'd4, 16'h0022);
    pulse(0, 3);
    rd(3'd2, v); check("R5 C second shift", v, 16'h0011);
    wr(3'd4, 16'h0077);
    pulse(2, 3);
    rd(3'd2, v); check("R5 pin2 ignored", v, 16'h0011);
    wr(3'd1, 16'h0BBB);
    wr(3'd4, 16'h0033);
    pulse(1, 3);
    rd(3'd1, v); check("R5 B new", v, 16'h0033);
    rd(3'd3, v); check("R5 D old B", v, 16'h0BBB);
    buf_c = 1'b0; buf_d = 1'b0;

    // R8 flags
    wr(3'd5, 16'h000F);
    rd(3'd5, v); check("R8 flags cleared", v, 16'h0000);
    pulse(0, 3);
    rd(3'd5, v); check("R8 flag A set", v, 16'h0001);
    wr(3'd5, 16'h0001, 1'b0);
    rd(3'd5, v); check("R8 byte clear ignored", v, 16'h0001);
    wr(3'd5, 16'h0001);
    rd(3'd5, v); check("R8 word clear", v, 16'h0000);

    // R9 counter wrap and hold
    cnt_en = 1'b1;
    wr(3'd4, 16'hFFFE);
    rd(3'd4, v); check("R9 counter after write", v, 16'hFFFE);
    @(negedge clk); @(negedge clk);
    rd(3'd4, v); check("R9 wrap", v, 16'h0000);
    cnt_en = 1'b0;
    repeat (3) @(negedge clk);
    rd(3'd4, v); check("R9 hold", v, 16'h0000);

    summary();
    $finish;
  end
endmodule